// File: doc/BRIEF.md
# Handshake-Based Pointer Crossing Unit

This unit carries a multi-bit binary pointer, such as a FIFO write or read index, from one clock domain into another. No assumption is made about how the two clocks relate. The pointer is never Gray coded. Instead, the source side copies its live pointer into a holding register that stays frozen. It then runs a four-phase request/acknowledge exchange with the destination side. Each of the two control bits crosses through its own two-flop synchronizer. Once the destination has seen the request, it takes a copy of the frozen holding register, so every bit of the copy belongs to the same snapshot.

The delivered pointer always trails the live one. A transfer may skip several counts when the source pointer moves during an exchange. Full or empty logic that compares against the delivered value can therefore be pessimistic, but it can never overrun. Each domain has its own asynchronous active-low reset. Inside the unit, that reset is released in step with its own clock.

The output side is a plain status interface with no back-pressure. `dst_ptr` is always valid to read. `dst_upd` pulses for one destination cycle when a new snapshot lands. The consumer cannot stall the unit, and the unit never waits on the consumer.

Top module: `hs_ptr_sync`

## Requirements
- R1: While its reset is held, and once it is released, the destination side shows `dst_ptr` = 0 and `dst_upd` = 0. The source side returns to its idle state.
- R2: The source side loads the live pointer into its holding register and raises the request only when it is idle. The request then stays high until the acknowledge, seen through the source-side synchronizer, is high.
- R3: The holding register does not change while the request is high. A delivered value is therefore never a mix of bits from two different pointer values.
- R4: The destination side takes the holding register into `dst_ptr` only on a rising edge of its synchronized request, and raises the acknowledge at the same time. `dst_upd` is high for exactly that one destination cycle. `dst_ptr` changes at no other time, apart from reset.
- R5: The source side drops the request only after it has seen the synchronized acknowledge high.
- R6: The destination side drops the acknowledge after the synchronized request goes low. The source side starts the next transfer only after it has seen the acknowledge low.
- R7: For a source pointer that never decreases, each delivered value is no lower than the previous delivered value and no higher than the live pointer at the moment of delivery.
- R8: Once `src_ptr` has been held constant for 80 source cycles, `dst_ptr` equals it. This holds for destination clock periods from 0.6 to 3 times the source period.
- R9: When `src_ptr` advances by one every source cycle, successive delivered values differ by more than one count. Each new transfer carries the latest pointer, not the next one.
- R10: The destination reset works alone. Asserting it clears `dst_ptr` at once. After it is released, without any source reset, the transfers resume and `dst_ptr` again follows `src_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_ptr | input | PTR_W | Live binary pointer in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_ptr | output | PTR_W | Last pointer snapshot delivered into the destination domain |
| dst_upd | output | 1 | One-cycle pulse when `dst_ptr` has just taken a new snapshot |

## Verification
A table of pointer values is held one at a time, with destination clocks slower than, equal to and faster than the source. This shows that the handshake always completes and converges, including at all-zeros and all-ones. A pointer that counts up every source cycle separates a unit that delivers the latest value from one that delivers values in sequence, and it also checks ordering and lag. A pointer that toggles between two bitwise-complementary values exposes any torn snapshot. A destination-only reset in the middle of a run, with the pointer changed during that reset, shows that the two domains recover independently.

// File: rtl/hsps_pkg.sv
package hsps_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/hsps_rst_sync.sv
module hsps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = q[STAGES-1];
endmodule

// File: rtl/hsps_bit_sync.sv
module hsps_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsps_src_side.sv
module hsps_src_side
  import hsps_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ptr_i,
  input  logic         ack_sync_i,
  output logic         req_o,
  output logic [W-1:0] hold_o
);
  src_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SRC_IDLE;
      req_o  <= 1'b0;
      hold_o <= '0;
    end else begin
      unique case (st)
        SRC_IDLE: begin
          hold_o <= ptr_i;
          req_o  <= 1'b1;
          st     <= SRC_WAIT_ACK;
        end
        SRC_WAIT_ACK: begin
          if (ack_sync_i) begin
            req_o <= 1'b0;
            st    <= SRC_WAIT_REL;
          end
        end
        SRC_WAIT_REL: begin
          if (!ack_sync_i) st <= SRC_IDLE;
        end
        default: st <= SRC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsps_dst_side.sv
module hsps_dst_side #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_sync_i,
  input  logic [W-1:0] hold_i,
  output logic         ack_o,
  output logic [W-1:0] ptr_o,
  output logic         upd_o
);
  logic req_d;
  logic req_rise;

  assign req_rise = req_sync_i && !req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      ack_o <= 1'b0;
      ptr_o <= '0;
      upd_o <= 1'b0;
    end else begin
      req_d <= req_sync_i;
      upd_o <= 1'b0;
      if (req_rise && !ack_o) begin
        ptr_o <= hold_i;
        ack_o <= 1'b1;
        upd_o <= 1'b1;
      end else if (!req_sync_i && ack_o) begin
        ack_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_ptr_sync.sv
module hs_ptr_sync
  import hsps_pkg::*;
#(
  parameter int unsigned PTR_W       = 5,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [PTR_W-1:0] src_ptr,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [PTR_W-1:0] dst_ptr,
  output logic             dst_upd
);
  logic             src_rst_q;
  logic             dst_rst_q;
  logic             hs_req;
  logic             hs_ack;
  logic             req_in_dst;
  logic             ack_in_src;
  logic [PTR_W-1:0] hold_q;

  hsps_rst_sync #(.STAGES(SYNC_STAGES)) u_src_rst (
    .clk(src_clk), .arst_n(src_rst_n), .rst_n_o(src_rst_q)
  );
  hsps_rst_sync #(.STAGES(SYNC_STAGES)) u_dst_rst (
    .clk(dst_clk), .arst_n(dst_rst_n), .rst_n_o(dst_rst_q)
  );

  hsps_src_side #(.W(PTR_W)) u_src (
    .clk(src_clk), .rst_n(src_rst_q), .ptr_i(src_ptr),
    .ack_sync_i(ack_in_src), .req_o(hs_req), .hold_o(hold_q)
  );

  hsps_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_q), .d(hs_req), .q(req_in_dst)
  );
  hsps_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_q), .d(hs_ack), .q(ack_in_src)
  );

  hsps_dst_side #(.W(PTR_W)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_q), .req_sync_i(req_in_dst),
    .hold_i(hold_q), .ack_o(hs_ack), .ptr_o(dst_ptr), .upd_o(dst_upd)
  );
endmodule

// File: rtl/hsps_checker.sv
module hsps_checker #(
  parameter int unsigned W = 5
) (
  input logic         src_clk,
  input logic         src_rst_q,
  input logic         dst_clk,
  input logic         dst_rst_q,
  input logic         hs_req,
  input logic         hs_ack,
  input logic         req_in_dst,
  input logic         ack_in_src,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] dst_ptr,
  input logic         dst_upd
);
  // R2: request is held until the synchronized acknowledge is seen
  a_r2_req_held: assert property (@(posedge src_clk) disable iff (!src_rst_q)
    (hs_req && !ack_in_src) |=> hs_req);

  // R3: snapshot frozen while the request is up
  a_r3_hold_stable: assert property (@(posedge src_clk) disable iff (!src_rst_q)
    (hs_req && $past(hs_req)) |-> $stable(hold_q));

  // R4: acknowledge rises only after the synchronized request was high
  a_r4_ack_after_req: assert property (@(posedge dst_clk) disable iff (!dst_rst_q)
    $rose(hs_ack) |-> $past(req_in_dst));

  // R4: output pointer moves only together with the update pulse
  a_r4_ptr_only_on_upd: assert property (@(posedge dst_clk) disable iff (!dst_rst_q)
    !dst_upd |-> $stable(dst_ptr));

  // R4: update pulse lasts one cycle
  a_r4_upd_single: assert property (@(posedge dst_clk) disable iff (!dst_rst_q)
    dst_upd |=> !dst_upd);

  // R5: request falls only after acknowledge was seen high
  a_r5_req_fall: assert property (@(posedge src_clk) disable iff (!src_rst_q)
    $fell(hs_req) |-> $past(ack_in_src));

  // R6: acknowledge falls only after request was seen low
  a_r6_ack_fall: assert property (@(posedge dst_clk) disable iff (!dst_rst_q)
    $fell(hs_ack) |-> !$past(req_in_dst));

  // R6: a new request rises only after acknowledge was seen low
  a_r6_req_rise: assert property (@(posedge src_clk) disable iff (!src_rst_q)
    $rose(hs_req) |-> !$past(ack_in_src));
endmodule

bind hs_ptr_sync hsps_checker #(.W(PTR_W)) u_chk (
  .src_clk(src_clk), .src_rst_q(src_rst_q), .dst_clk(dst_clk),
  .dst_rst_q(dst_rst_q), .hs_req(hs_req), .hs_ack(hs_ack),
  .req_in_dst(req_in_dst), .ack_in_src(ack_in_src), .hold_q(hold_q),
  .dst_ptr(dst_ptr), .dst_upd(dst_upd)
);

// File: tb/hs_ptr_sync_tb.sv
`timescale 1ns/1ps
module hs_ptr_sync_tb;
  localparam int W      = 5;
  localparam int SETTLE = 80;
  localparam int NV     = 9;
  localparam int VEC_PTR  [NV] = '{9, 0, 31, 16, 15, 21, 10, 31, 1};
  localparam int VEC_HALF [NV] = '{5, 5, 5, 3, 3, 15, 15, 7, 7};

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n = 1'b0;
  logic         dst_rst_n = 1'b0;
  logic [W-1:0] src_ptr = '0;
  logic [W-1:0] dst_ptr;
  logic         dst_upd;

  int dst_half = 5;
  int checks = 0;
  int errors = 0;

  // monitor state: mode 0 off, 1 ordering/lag, 2 torn-value
  int           mon_mode = 0;
  int           prev_val = 0;
  int           max_jump = 0;
  int           upd_seen = 0;
  logic         prev_upd = 1'b0;
  logic [W-1:0] last_ptr = '0;

  hs_ptr_sync #(.PTR_W(W)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_ptr(src_ptr),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_ptr(dst_ptr), .dst_upd(dst_upd)
  );

  always #5 src_clk = ~src_clk;
  always begin
    #(dst_half);
    dst_clk = ~dst_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic src_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge src_clk);
  endtask

  // destination-side monitor, sampled on the falling edge
  always @(negedge dst_clk) begin
    if (!dst_rst_n) begin
      last_ptr = dst_ptr;
      prev_upd = 1'b0;
    end else begin
      if (dst_upd) begin
        chk(!prev_upd, "R4 update pulse width", 2, 1);
      end else if (dst_ptr != last_ptr) begin
        chk(1'b0, "R4 dst_ptr moved without update", int'(dst_ptr), int'(last_ptr));
      end
      if (dst_upd && mon_mode == 1) begin
        upd_seen++;
        chk(int'(dst_ptr) >= prev_val, "R7 delivered value not decreasing", int'(dst_ptr), prev_val);
        chk(int'(dst_ptr) <= int'(src_ptr), "R7 delivered value not ahead of live", int'(dst_ptr), int'(src_ptr));
        if (int'(dst_ptr) - prev_val > max_jump) max_jump = int'(dst_ptr) - prev_val;
        prev_val = int'(dst_ptr);
      end
      if (dst_upd && mon_mode == 2) begin
        chk(dst_ptr == 5'd10 || dst_ptr == 5'd21, "R3 R7 no torn snapshot", int'(dst_ptr), 10);
      end
      last_ptr = dst_ptr;
      prev_upd = dst_upd;
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, with a nonzero source pointer present
    src_ptr = 5'd9;
    #43;
    chk(dst_ptr == '0, "R1 dst_ptr in reset", int'(dst_ptr), 0);
    chk(dst_upd == 1'b0, "R1 dst_upd in reset", int'(dst_upd), 0);
    @(negedge src_clk);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(negedge dst_clk);
    chk(dst_ptr == '0, "R1 dst_ptr just after release", int'(dst_ptr), 0);
    chk(dst_upd == 1'b0, "R1 dst_upd just after release", int'(dst_upd), 0);

    // R8 table walk (full R2 R5 R6 handshakes under several clock ratios)
    for (int i = 0; i < NV; i++) begin
      @(negedge src_clk);
      dst_half = VEC_HALF[i];
      src_ptr  = W'(VEC_PTR[i]);
      src_cycles(SETTLE);
      chk(int'(dst_ptr) == VEC_PTR[i], "R8 R2 R5 R6 converge to held pointer", int'(dst_ptr), VEC_PTR[i]);
    end

    // R7 and R9: count up one per source cycle
    dst_half = 5;
    @(negedge src_clk);
    src_ptr = '0;
    src_cycles(SETTLE);
    prev_val = 0;
    max_jump = 0;
    upd_seen = 0;
    mon_mode = 1;
    for (int v = 1; v <= 28; v++) begin
      @(negedge src_clk);
      src_ptr = W'(v);
    end
    src_cycles(SETTLE);
    mon_mode = 0;
    chk(upd_seen > 2, "R7 updates observed during count", upd_seen, 3);
    chk(max_jump > 1, "R9 transfer skips to latest pointer", max_jump, 2);
    chk(int'(dst_ptr) == 28, "R8 final value after count", int'(dst_ptr), 28);

    // R3: complementary toggling pointer
    mon_mode = 2;
    for (int t = 0; t < 200; t++) begin
      @(negedge src_clk);
      src_ptr = t[0] ? 5'd21 : 5'd10;
    end
    @(negedge src_clk);
    src_ptr = 5'd21;
    src_cycles(SETTLE);
    mon_mode = 0;
    chk(int'(dst_ptr) == 21, "R3 R8 value after toggling", int'(dst_ptr), 21);

    // R10: destination-only reset mid-run
    @(negedge src_clk);
    src_ptr = 5'd19;
    src_cycles(SETTLE);
    dst_rst_n = 1'b0;
    #2;
    chk(dst_ptr == '0, "R10 destination reset clears output", int'(dst_ptr), 0);
    @(negedge src_clk);
    src_ptr = 5'd6;
    src_cycles(5);
    dst_rst_n = 1'b1;
    src_cycles(SETTLE);
    chk(int'(dst_ptr) == 6, "R10 recovery without source reset", int'(dst_ptr), 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule